// File: doc/BRIEF.md
# ECC Fault Injection Controller

This block sits between an ECC-protected RAM and its error-checking logic. On a chosen access it flips one or two data bits, so that the single-error correction and double-error detection paths can be exercised in the field without touching the RAM contents. Software programs a control register, a target row and a pair of bit indices. After that, every access that qualifies passes its data word through an XOR mask.

An access qualifies when its row equals the target row, or when the next-access mode is set, in which case the row is ignored. Write accesses qualify only in write-through mode. The force bits can be left armed, which corrupts every qualifying access. They can instead be made one-shot, in which case the block clears them itself. A double-bit force clears right after its injection. A single-bit force clears either after the corrected read or after the correcting writeback, depending on whether writeback is enabled.

The data path is combinational, so a corrupted word appears in the same cycle as the access. The ECC generate, check and partial-write read-modify-write enables are held in the same register and driven out to the neighbouring ECC logic.

Top module: `ecc_fault_inject`

## Requirements
- R1: After reset the control register reads 0x07: ECC generate (bit 0), ECC check (bit 1) and partial-write RMW (bit 2) are 1. Force single (bit 3), force double (bit 4), next-access (bit 5) and one-shot (bit 6) are 0. Data passes through unchanged.
- R2: ecc_bypass is 1 exactly when both ECC generate and ECC check are 0. While it is 1, no access is corrupted.
- R3: With next-access at 0, only an access whose row equals the target row register is corrupted. With next-access at 1, any row is corrupted.
- R4: A single-bit force flips the data bit whose index is held in bits 15:0 of the bit-select register, and raises inj_single in the same cycle.
- R5: A double-bit force also flips the bit indexed by bits 31:16 and raises inj_double. When both force bits are set, the double force takes precedence.
- R6: A bit index at or above the data width flips no bit.
- R7: A write access is corrupted only while write_thru is 1. Read accesses are corrupted regardless of write_thru.
- R8: With one-shot set, the double force bit reads 0 from the cycle after its injection, and later accesses are not corrupted.
- R9: With one-shot set and writeback disabled, the single force bit reads 0 from the cycle after the corrupted access, and later accesses are not corrupted.
- R10: With one-shot set and writeback enabled, the single force bit stays 1 after a corrupted read. It injects no further errors, and it reads 0 from the cycle after wb_done.
- R11: With one-shot clear, the force bits stay set, and every qualifying access is corrupted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_we | input | 1 | Write strobe for the control register |
| ctrl_wdata | input | 7 | Control register write value |
| row_we | input | 1 | Write strobe for the target row register |
| row_wdata | input | RW (32) | Target row write value |
| sel_we | input | 1 | Write strobe for the bit-select register |
| sel_wdata | input | 2*IDXW (32) | Bit indices: second in upper half, first in lower half |
| write_thru | input | 1 | Write-through mode: writes are also eligible |
| wb_en | input | 1 | Correcting writeback is enabled |
| wb_done | input | 1 | Pulse: correcting writeback has been performed |
| acc_valid | input | 1 | RAM access strobe |
| acc_write | input | 1 | Access is a write |
| acc_row | input | RW (32) | Row address of the access |
| data_in | input | DW (32) | Data word of the access |
| data_out | output | DW (32) | Data word with the forced bits flipped |
| inj_single | output | 1 | A single-bit error is injected this cycle |
| inj_double | output | 1 | A double-bit error is injected this cycle |
| ctrl_q | output | 7 | Current control register value |
| ecc_gen_en | output | 1 | ECC generate enable |
| ecc_chk_en | output | 1 | ECC check enable |
| rmw_en | output | 1 | Read-modify-write enable for partial writes |
| ecc_bypass | output | 1 | ECC path fully bypassed |

## Verification
data_out, inj_single and inj_double are combinational, so they are due in the same cycle that acc_valid is high. The bench drives each access on a falling edge and samples these outputs 1 ns later. Self-clearing of a force bit takes effect at the rising edge that ends the injecting access, or at the edge that ends the wb_done pulse. The bench therefore reads ctrl_q at the falling edge after that rising edge, never before it. Configuration writes take one edge, and each test waits a full cycle after a write before it starts an access.

// File: rtl/ecc_inj_pkg.sv
`timescale 1ns/1ps
// Package: shared widths and control-register bit positions for the
// ECC fault injection controller. Assumes a 7-bit control register.
package ecc_inj_pkg;
    localparam int CTRL_W   = 7;
    localparam int B_GEN    = 0;
    localparam int B_CHK    = 1;
    localparam int B_RMW    = 2;
    localparam int B_FSEC   = 3;
    localparam int B_FDED   = 4;
    localparam int B_FNEXT  = 5;
    localparam int B_ONCE   = 6;
    localparam logic [CTRL_W-1:0] CTRL_RST = 7'h07;
endpackage

// File: rtl/ecc_inj_mask.sv
`timescale 1ns/1ps
// Module: builds the XOR mask from one or two bit indices.
// Assumes indices are unsigned; an index >= DW matches no bit.
module ecc_inj_mask #(
    parameter int DW   = 32,
    parameter int IDXW = 16
) (
    input  logic [IDXW-1:0] idx_a,
    input  logic [IDXW-1:0] idx_b,
    input  logic            dbl,
    output logic [DW-1:0]   mask
);
    // One compare pair per data bit.
    for (genvar i = 0; i < DW; i++) begin : g_bit
        assign mask[i] = (idx_a == IDXW'(i)) | (dbl & (idx_b == IDXW'(i)));
    end
endmodule

// File: rtl/ecc_inj_match.sv
`timescale 1ns/1ps
// Module: decides whether the current access is corrupted and how.
// Assumes double force takes precedence over single force.
module ecc_inj_match #(
    parameter int RW = 32
) (
    input  logic          acc_valid,
    input  logic          acc_write,
    input  logic          write_thru,
    input  logic [RW-1:0] acc_row,
    input  logic [RW-1:0] target_row,
    input  logic          force_next,
    input  logic          force_sec,
    input  logic          force_ded,
    input  logic          bypass,
    input  logic          sec_wait,
    output logic          inj_single,
    output logic          inj_double
);
    logic hit;

    // Qualify access: strobe, ECC active, write-through, row or next-access.
    always_comb begin
        hit        = acc_valid && !bypass && (!acc_write || write_thru)
                     && (force_next || (acc_row == target_row));
        inj_double = hit && force_ded;
        inj_single = hit && force_sec && !force_ded && !sec_wait;
    end
endmodule

// File: rtl/ecc_inj_ctrl.sv
`timescale 1ns/1ps
// Module: control, target-row and bit-select registers with one-shot
// self-clearing of the force bits. Assumes a software write wins over
// any self-clear in the same cycle.
module ecc_inj_ctrl
    import ecc_inj_pkg::*;
#(
    parameter int RW   = 32,
    parameter int IDXW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              row_we,
    input  logic [RW-1:0]     row_wdata,
    input  logic              sel_we,
    input  logic [2*IDXW-1:0] sel_wdata,
    input  logic              acc_write,
    input  logic              wb_en,
    input  logic              wb_done,
    input  logic              inj_single,
    input  logic              inj_double,
    output logic [CTRL_W-1:0] ctrl,
    output logic [RW-1:0]     target_row,
    output logic [2*IDXW-1:0] bit_sel,
    output logic              sec_wait
);
    // Target row and bit-select registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target_row <= '0;
            bit_sel    <= '0;
        end else begin
            if (row_we) target_row <= row_wdata;
            if (sel_we) bit_sel    <= sel_wdata;
        end
    end

    // Control register with one-shot clearing of force bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl     <= CTRL_RST;
            sec_wait <= 1'b0;
        end else if (ctrl_we) begin
            ctrl     <= ctrl_wdata;
            sec_wait <= 1'b0;
        end else if (ctrl[B_ONCE]) begin
            if (inj_double) ctrl[B_FDED] <= 1'b0;
            if (inj_single) begin
                if (wb_en && !acc_write) sec_wait      <= 1'b1;
                else                     ctrl[B_FSEC]  <= 1'b0;
            end
            if (sec_wait && wb_done) begin
                ctrl[B_FSEC] <= 1'b0;
                sec_wait     <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ecc_fault_inject.sv
`timescale 1ns/1ps
// Module: ECC fault injection controller top. Flips selected data bits
// on qualifying RAM accesses (combinational path) and exports the ECC
// enables. Assumes one access per cycle on acc_valid.
module ecc_fault_inject
    import ecc_inj_pkg::*;
#(
    parameter int DW   = 32,
    parameter int RW   = 32,
    parameter int IDXW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [6:0]        ctrl_wdata,
    input  logic              row_we,
    input  logic [RW-1:0]     row_wdata,
    input  logic              sel_we,
    input  logic [2*IDXW-1:0] sel_wdata,
    input  logic              write_thru,
    input  logic              wb_en,
    input  logic              wb_done,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [RW-1:0]     acc_row,
    input  logic [DW-1:0]     data_in,
    output logic [DW-1:0]     data_out,
    output logic              inj_single,
    output logic              inj_double,
    output logic [6:0]        ctrl_q,
    output logic              ecc_gen_en,
    output logic              ecc_chk_en,
    output logic              rmw_en,
    output logic              ecc_bypass
);
    logic [CTRL_W-1:0] ctrl;
    logic [RW-1:0]     target_row;
    logic [2*IDXW-1:0] bit_sel;
    logic              sec_wait;
    logic [DW-1:0]     mask;

    ecc_inj_ctrl #(.RW(RW), .IDXW(IDXW)) i_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .row_we(row_we), .row_wdata(row_wdata),
        .sel_we(sel_we), .sel_wdata(sel_wdata),
        .acc_write(acc_write), .wb_en(wb_en), .wb_done(wb_done),
        .inj_single(inj_single), .inj_double(inj_double),
        .ctrl(ctrl), .target_row(target_row), .bit_sel(bit_sel),
        .sec_wait(sec_wait)
    );

    ecc_inj_match #(.RW(RW)) i_match (
        .acc_valid(acc_valid), .acc_write(acc_write),
        .write_thru(write_thru), .acc_row(acc_row),
        .target_row(target_row),
        .force_next(ctrl[B_FNEXT]), .force_sec(ctrl[B_FSEC]),
        .force_ded(ctrl[B_FDED]), .bypass(ecc_bypass),
        .sec_wait(sec_wait),
        .inj_single(inj_single), .inj_double(inj_double)
    );

    ecc_inj_mask #(.DW(DW), .IDXW(IDXW)) i_mask (
        .idx_a(bit_sel[IDXW-1:0]), .idx_b(bit_sel[2*IDXW-1:IDXW]),
        .dbl(inj_double), .mask(mask)
    );

    // Output data and enable decode.
    always_comb begin
        data_out   = data_in ^ (mask & {DW{inj_single | inj_double}});
        ctrl_q     = ctrl;
        ecc_gen_en = ctrl[B_GEN];
        ecc_chk_en = ctrl[B_CHK];
        rmw_en     = ctrl[B_RMW];
        ecc_bypass = !ctrl[B_GEN] && !ctrl[B_CHK];
    end
endmodule

// File: rtl/ecc_fault_inject_chk.sv
`timescale 1ns/1ps
// Checker: temporal properties of the fault injection controller,
// bound to the top. Assumes synchronous active-low reset.
module ecc_fault_inject_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ctrl_we,
    input logic          write_thru,
    input logic          wb_en,
    input logic          acc_valid,
    input logic          acc_write,
    input logic [DW-1:0] data_in,
    input logic [DW-1:0] data_out,
    input logic          inj_single,
    input logic          inj_double,
    input logic [6:0]    ctrl_q,
    input logic          ecc_bypass
);
    assert_bypass_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_bypass |-> (!inj_single && !inj_double));

    assert_clean_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!inj_single && !inj_double) |-> (data_out == data_in));

    assert_single_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        inj_single |-> ($countones(data_out ^ data_in) <= 1));

    assert_double_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        inj_double |-> ($countones(data_out ^ data_in) <= 2));

    assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(inj_single && inj_double));

    assert_write_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && !write_thru) |-> (!inj_single && !inj_double));

    assert_ded_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_double && ctrl_q[6] && !ctrl_we) |=> !ctrl_q[4]);

    assert_sec_hold_wb_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_single && ctrl_q[6] && wb_en && !acc_write && !ctrl_we) |=> ctrl_q[3]);

    assert_force_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[6] && !ctrl_we) |=> (ctrl_q[4:3] == $past(ctrl_q[4:3])));
endmodule

bind ecc_fault_inject ecc_fault_inject_chk #(.DW(DW)) i_chk (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .write_thru(write_thru),
    .wb_en(wb_en), .acc_valid(acc_valid), .acc_write(acc_write),
    .data_in(data_in), .data_out(data_out), .inj_single(inj_single),
    .inj_double(inj_double), .ctrl_q(ctrl_q), .ecc_bypass(ecc_bypass)
);

// File: tb/test_ecc_fault_inject.sv
`timescale 1ns/1ps
// Bench: directed scenarios for the ECC fault injection controller.
module test_ecc_fault_inject;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_we = 1'b0;
    logic [6:0]  ctrl_wdata = '0;
    logic        row_we = 1'b0;
    logic [31:0] row_wdata = '0;
    logic        sel_we = 1'b0;
    logic [31:0] sel_wdata = '0;
    logic        write_thru = 1'b0;
    logic        wb_en = 1'b0;
    logic        wb_done = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [31:0] acc_row = '0;
    logic [31:0] data_in = '0;
    logic [31:0] data_out;
    logic        inj_single, inj_double;
    logic [6:0]  ctrl_q;
    logic        ecc_gen_en, ecc_chk_en, rmw_en, ecc_bypass;

    int          checks = 0;
    int          failures = 0;
    logic [31:0] cap_out;
    logic        cap_s, cap_d;

    always #4 clk = ~clk;

    ecc_fault_inject i_ecc_fault_inject (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .row_we(row_we), .row_wdata(row_wdata), .sel_we(sel_we),
        .sel_wdata(sel_wdata), .write_thru(write_thru), .wb_en(wb_en),
        .wb_done(wb_done), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_row(acc_row), .data_in(data_in), .data_out(data_out),
        .inj_single(inj_single), .inj_double(inj_double), .ctrl_q(ctrl_q),
        .ecc_gen_en(ecc_gen_en), .ecc_chk_en(ecc_chk_en), .rmw_en(rmw_en),
        .ecc_bypass(ecc_bypass)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_ctrl(input logic [6:0] v);
        @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk); ctrl_we = 1'b0;
    endtask

    task automatic set_row(input logic [31:0] v);
        @(negedge clk); row_we = 1'b1; row_wdata = v;
        @(negedge clk); row_we = 1'b0;
    endtask

    task automatic set_sel(input logic [15:0] second, input logic [15:0] first);
        @(negedge clk); sel_we = 1'b1; sel_wdata = {second, first};
        @(negedge clk); sel_we = 1'b0;
    endtask

    // One access cycle; returns at the falling edge after its rising edge.
    task automatic access(input logic wr, input logic [31:0] row, input logic [31:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_row = row; data_in = d;
        #1;
        cap_out = data_out; cap_s = inj_single; cap_d = inj_double;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic t_reset;
        check(ctrl_q == 7'h07, "R1 ctrl reset", 32'(ctrl_q), 32'h07);
        check(ecc_gen_en && ecc_chk_en && rmw_en && !ecc_bypass, "R1 enables",
              {28'd0, ecc_gen_en, ecc_chk_en, rmw_en, ecc_bypass}, 32'he);
        access(1'b0, 32'd0, 32'h1234_5678);
        check(cap_out == 32'h1234_5678 && !cap_s && !cap_d, "R1 passthrough",
              cap_out, 32'h1234_5678);
    endtask

    task automatic t_row_single;
        set_row(32'd5);
        set_sel(16'd0, 16'd3);
        set_ctrl(7'h07 | 7'h08);
        access(1'b0, 32'd4, 32'hA5A5_0000);
        check(cap_out == 32'hA5A5_0000 && !cap_s, "R3 row miss", cap_out, 32'hA5A5_0000);
        access(1'b0, 32'd5, 32'hA5A5_0000);
        check(cap_out == (32'hA5A5_0000 ^ (32'd1 << 3)) && cap_s, "R4 single flip",
              cap_out, 32'hA5A5_0000 ^ (32'd1 << 3));
        check(ctrl_q[3] == 1'b1, "R11 force stays", 32'(ctrl_q), 32'h0f);
        access(1'b0, 32'd5, 32'hFFFF_FFFF);
        check(cap_out == (32'hFFFF_FFFF ^ (32'd1 << 3)), "R11 repeat corrupt",
              cap_out, 32'hFFFF_FFFF ^ (32'd1 << 3));
    endtask

    task automatic t_next_access;
        set_ctrl(7'h07 | 7'h08 | 7'h20);
        access(1'b0, 32'd99, 32'h0);
        check(cap_out == (32'd1 << 3) && cap_s, "R3 next-access any row",
              cap_out, 32'd1 << 3);
    endtask

    task automatic t_double;
        set_sel(16'd31, 16'd0);
        set_ctrl(7'h07 | 7'h10 | 7'h20);
        access(1'b0, 32'd7, 32'h0F0F_0F0F);
        check(cap_out == (32'h0F0F_0F0F ^ 32'h8000_0001) && cap_d && !cap_s,
              "R5 double flip", cap_out, 32'h0F0F_0F0F ^ 32'h8000_0001);
        set_ctrl(7'h07 | 7'h18 | 7'h20);
        access(1'b0, 32'd7, 32'h0);
        check(cap_out == 32'h8000_0001 && cap_d && !cap_s, "R5 double wins",
              cap_out, 32'h8000_0001);
    endtask

    task automatic t_idx_range;
        set_sel(16'd0, 16'd40);
        set_ctrl(7'h07 | 7'h08 | 7'h20);
        access(1'b0, 32'd1, 32'h5555_AAAA);
        check(cap_out == 32'h5555_AAAA, "R6 index out of range", cap_out, 32'h5555_AAAA);
        set_sel(16'd32, 16'd2);
        set_ctrl(7'h07 | 7'h10 | 7'h20);
        access(1'b0, 32'd1, 32'h0);
        check(cap_out == 32'h4, "R6 second index out of range", cap_out, 32'h4);
    endtask

    task automatic t_write;
        set_sel(16'd0, 16'd8);
        set_ctrl(7'h07 | 7'h08 | 7'h20);
        write_thru = 1'b0;
        access(1'b1, 32'd2, 32'h0);
        check(cap_out == 32'h0 && !cap_s, "R7 write no thru", cap_out, 32'h0);
        access(1'b0, 32'd2, 32'h0);
        check(cap_out == 32'h100, "R7 read without thru", cap_out, 32'h100);
        write_thru = 1'b1;
        access(1'b1, 32'd2, 32'h0);
        check(cap_out == 32'h100 && cap_s, "R7 write thru", cap_out, 32'h100);
        write_thru = 1'b0;
    endtask

    task automatic t_bypass;
        set_sel(16'd0, 16'd1);
        set_ctrl(7'h08 | 7'h20);
        check(ecc_bypass == 1'b1, "R2 bypass flag", 32'(ecc_bypass), 32'd1);
        access(1'b0, 32'd0, 32'h0);
        check(cap_out == 32'h0 && !cap_s, "R2 no inject in bypass", cap_out, 32'h0);
        set_ctrl(7'h01 | 7'h08 | 7'h20);
        check(ecc_bypass == 1'b0, "R2 gen only not bypass", 32'(ecc_bypass), 32'd0);
    endtask

    task automatic t_once_ded;
        set_sel(16'd5, 16'd6);
        set_ctrl(7'h07 | 7'h10 | 7'h20 | 7'h40);
        access(1'b0, 32'd0, 32'h0);
        check(cap_out == 32'h60 && cap_d, "R8 first inject", cap_out, 32'h60);
        check(ctrl_q[4] == 1'b0, "R8 force double cleared", 32'(ctrl_q), 32'h67);
        access(1'b0, 32'd0, 32'h0);
        check(cap_out == 32'h0 && !cap_d, "R8 no later inject", cap_out, 32'h0);
    endtask

    task automatic t_once_sec_nowb;
        wb_en = 1'b0;
        set_sel(16'd0, 16'd12);
        set_ctrl(7'h07 | 7'h08 | 7'h20 | 7'h40);
        access(1'b0, 32'd0, 32'h0);
        check(cap_out == 32'h1000 && cap_s, "R9 first inject", cap_out, 32'h1000);
        check(ctrl_q[3] == 1'b0, "R9 force single cleared", 32'(ctrl_q), 32'h67);
        access(1'b0, 32'd0, 32'h0);
        check(cap_out == 32'h0, "R9 no later inject", cap_out, 32'h0);
    endtask

    task automatic t_once_sec_wb;
        wb_en = 1'b1;
        set_sel(16'd0, 16'd20);
        set_ctrl(7'h07 | 7'h08 | 7'h20 | 7'h40);
        access(1'b0, 32'd0, 32'h0);
        check(cap_out == 32'h0010_0000 && cap_s, "R10 first inject",
              cap_out, 32'h0010_0000);
        check(ctrl_q[3] == 1'b1, "R10 force held for writeback", 32'(ctrl_q), 32'h6f);
        access(1'b0, 32'd0, 32'h0);
        check(cap_out == 32'h0 && !cap_s, "R10 no inject while waiting", cap_out, 32'h0);
        @(negedge clk); wb_done = 1'b1;
        @(negedge clk); wb_done = 1'b0;
        check(ctrl_q[3] == 1'b0, "R10 cleared after writeback", 32'(ctrl_q), 32'h67);
        wb_en = 1'b0;
    endtask

    initial begin
        #800000;
        failures++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_row_single();
        t_next_access();
        t_double();
        t_idx_range();
        t_write();
        t_bypass();
        t_once_ded();
        t_once_sec_nowb();
        t_once_sec_wb();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule